// File: doc/BRIEF.md
# Split-Bank Unaligned Load Extractor

This block forms the load-data path of a level-one data cache whose storage is divided into two banks: one holding the even-numbered 16-byte lines and one holding the odd-numbered lines. For every load address it computes the index of the even line and the index of the odd line to read, so that the two consecutive lines covering the address are available together. It joins them in address order and extracts an eight-byte window starting at any byte offset. An unaligned load that crosses a 16-byte line boundary therefore completes in a single cycle.

The eight-byte window is trimmed to the requested width of 1, 2, 4 or 8 bytes, then sign-extended or zero-extended. A 16-byte wide load skips the window path. It returns the whole line that holds the address, but only when the address is a multiple of 16. For any other address it raises a fault and returns no data. The result, the fault flag and a valid strobe are registered and appear one clock after the request.

Top module: `xl_load_extract`

## Requirements
- R1: When address bit 4 is 0, `even_idx` and `odd_idx` both equal the pair index `req_addr[ADDR_W-1:5]`, combinationally from the address.
- R2: When address bit 4 is 1, `odd_idx` equals the pair index and `even_idx` equals the pair index plus one, wrapping to 0 after the last pair.
- R3: For a narrow load, the result holds the eight bytes at addresses `req_addr` to `req_addr+7`. Byte b of a line sits in bits 8b+7:8b. The line at the request address comes first, and bytes past its end come from the following line.
- R4: `req_size` selects the width: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes. With `req_signed` at 0, the bits above the selected width are zero.
- R5: With `req_signed` at 1, the bits above the selected width copy the top bit of the selected width, up to bit 63.
- R6: For a narrow load, `rsp_data[127:64]` is zero.
- R7: A wide load (`req_wide`=1) whose address has bits 3:0 equal to zero returns all 16 bytes of the line holding the address, with byte 0 in bits 7:0. `req_size` and `req_signed` have no effect on it, and `rsp_fault` is 0.
- R8: A wide load whose address has a nonzero value in bits 3:0 sets `rsp_fault` to 1 and returns all-zero data.
- R9: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` at 1. A cycle without a request leaves `rsp_data` unchanged.
- R10: While `rst` is high, `rsp_valid`, `rsp_fault` and `rsp_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request strobe |
| req_addr | input | ADDR_W | Byte address of the load |
| req_size | input | 2 | Width code: 0 means 1 byte, 1 means 2, 2 means 4, 3 means 8 |
| req_signed | input | 1 | 1 selects sign extension, 0 selects zero extension |
| req_wide | input | 1 | 1 requests an aligned 16-byte load |
| even_idx | output | ADDR_W-5 | Row index for the even-line bank |
| odd_idx | output | ADDR_W-5 | Row index for the odd-line bank |
| even_line | input | 128 | Line read from the even bank at `even_idx` |
| odd_line | input | 128 | Line read from the odd bank at `odd_idx` |
| rsp_valid | output | 1 | Result strobe, one cycle after a request |
| rsp_fault | output | 1 | Misaligned wide-load fault |
| rsp_data | output | 128 | Extended narrow result or full wide line |

## Verification
The bench builds the block with its defaults: a 12-bit address, which gives 128 line pairs, with 16-byte lines and an eight-byte window. The address space is small enough that a load near the top address crosses into pair 0, so the wrap of the even index can be reached directly. Every byte offset inside a line can also cross into the neighbouring bank in either order. The bench's bank model fills each line with a byte pattern that depends on the bank, the row and the byte position, and many of its bytes have the top bit set. With that pattern, a wrong bank choice, a wrong row or a wrong byte order gives a different value, and the sign-extension cases reach negative values.

// File: rtl/xl_pkg.sv
package xl_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } ld_size_e;
endpackage

// File: rtl/xl_bank_index.sv
module xl_bank_index #(
  parameter int ADDR_W = 12,
  parameter int OFF_W  = 4,
  localparam int IDX_W = ADDR_W - OFF_W - 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  even_idx,
  output logic [IDX_W-1:0]  odd_idx,
  output logic              odd_first
);
  logic [IDX_W-1:0] pair;
  assign pair      = addr[ADDR_W-1:OFF_W+1];
  assign odd_first = addr[OFF_W];
  assign odd_idx   = pair;
  assign even_idx  = odd_first ? IDX_W'(pair + 1'b1) : pair;
endmodule

// File: rtl/xl_splice_extract.sv
module xl_splice_extract #(
  parameter int LINE_BYTES = 16,
  parameter int WIN_BYTES  = 8,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int WIN_W  = WIN_BYTES * 8
) (
  input  logic              odd_first,
  input  logic [OFF_W-1:0]  offset,
  input  logic [LINE_W-1:0] even_line,
  input  logic [LINE_W-1:0] odd_line,
  output logic [WIN_W-1:0]  window,
  output logic [LINE_W-1:0] first_line
);
  logic [7:0] pair_b [2*LINE_BYTES];

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_pair
    assign pair_b[b]            = odd_first ? odd_line[8*b +: 8]  : even_line[8*b +: 8];
    assign pair_b[b+LINE_BYTES] = odd_first ? even_line[8*b +: 8] : odd_line[8*b +: 8];
  end

  for (genvar k = 0; k < WIN_BYTES; k++) begin : g_win
    logic [OFF_W:0] pos;
    assign pos              = (OFF_W+1)'(offset) + (OFF_W+1)'(k);
    assign window[8*k +: 8] = pair_b[pos];
  end

  assign first_line = odd_first ? odd_line : even_line;
endmodule

// File: rtl/xl_extend.sv
module xl_extend import xl_pkg::*; #(
  parameter int WIN_BYTES = 8,
  localparam int WIN_W = WIN_BYTES * 8
) (
  input  logic [WIN_W-1:0] window,
  input  logic [1:0]       size,
  input  logic             sgn,
  output logic [WIN_W-1:0] ext
);
  always_comb begin
    case (ld_size_e'(size))
      SZ_BYTE: ext = {{(WIN_W-8){sgn & window[7]}},   window[7:0]};
      SZ_HALF: ext = {{(WIN_W-16){sgn & window[15]}}, window[15:0]};
      SZ_WORD: ext = {{(WIN_W-32){sgn & window[31]}}, window[31:0]};
      default: ext = window;
    endcase
  end
endmodule

// File: rtl/xl_load_extract.sv
module xl_load_extract #(
  parameter int ADDR_W     = 12,
  parameter int LINE_BYTES = 16,
  parameter int WIN_BYTES  = 8,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = ADDR_W - OFF_W - 1,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int WIN_W  = WIN_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic              req_wide,
  output logic [IDX_W-1:0]  even_idx,
  output logic [IDX_W-1:0]  odd_idx,
  input  logic [LINE_W-1:0] even_line,
  input  logic [LINE_W-1:0] odd_line,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [LINE_W-1:0] rsp_data
);
  logic              odd_first;
  logic [WIN_W-1:0]  window;
  logic [WIN_W-1:0]  extended;
  logic [LINE_W-1:0] first_line;
  logic              wide_ok;
  logic [LINE_W-1:0] nxt_data;
  logic              nxt_fault;

  xl_bank_index #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_index (
    .addr      (req_addr),
    .even_idx  (even_idx),
    .odd_idx   (odd_idx),
    .odd_first (odd_first)
  );

  xl_splice_extract #(.LINE_BYTES(LINE_BYTES), .WIN_BYTES(WIN_BYTES)) u_splice (
    .odd_first  (odd_first),
    .offset     (req_addr[OFF_W-1:0]),
    .even_line  (even_line),
    .odd_line   (odd_line),
    .window     (window),
    .first_line (first_line)
  );

  xl_extend #(.WIN_BYTES(WIN_BYTES)) u_ext (
    .window (window),
    .size   (req_size),
    .sgn    (req_signed),
    .ext    (extended)
  );

  assign wide_ok   = (req_addr[OFF_W-1:0] == '0);
  assign nxt_fault = req_wide & ~wide_ok;

  always_comb begin
    if (req_wide) nxt_data = wide_ok ? first_line : '0;
    else          nxt_data = {{(LINE_W-WIN_W){1'b0}}, extended};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault <= nxt_fault;
        rsp_data  <= nxt_data;
      end
    end
  end
endmodule

// File: rtl/xl_load_extract_chk.sv
module xl_load_extract_chk #(
  parameter int ADDR_W     = 12,
  parameter int LINE_BYTES = 16,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = ADDR_W - OFF_W - 1,
  localparam int LINE_W = LINE_BYTES * 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              req_signed,
  input logic              req_wide,
  input logic [IDX_W-1:0]  even_idx,
  input logic [IDX_W-1:0]  odd_idx,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [LINE_W-1:0] rsp_data
);
  assert_same_row_R1: assert property (@(posedge clk) disable iff (rst)
    !req_addr[OFF_W] |-> (even_idx == odd_idx && odd_idx == req_addr[ADDR_W-1:OFF_W+1]));

  assert_even_next_R2: assert property (@(posedge clk) disable iff (rst)
    req_addr[OFF_W] |-> (even_idx == IDX_W'(odd_idx + 1'b1)));

  assert_zero_ext_byte_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_wide && req_size == 2'd0 && !req_signed) |=> (rsp_data[LINE_W-1:8] == '0));

  assert_sign_ext_byte_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_wide && req_size == 2'd0 && req_signed) |=> (rsp_data[63:8] == {56{rsp_data[7]}}));

  assert_upper_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_wide) |=> (rsp_data[LINE_W-1:64] == '0 && !rsp_fault));

  assert_misaligned_fault_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_wide && req_addr[OFF_W-1:0] != '0) |=> (rsp_fault && rsp_data == '0));

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && $stable(rsp_data)));
endmodule

bind xl_load_extract xl_load_extract_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .req_size   (req_size),
  .req_signed (req_signed),
  .req_wide   (req_wide),
  .even_idx   (even_idx),
  .odd_idx    (odd_idx),
  .rsp_valid  (rsp_valid),
  .rsp_fault  (rsp_fault),
  .rsp_data   (rsp_data)
);

// File: tb/xl_load_extract_tb.sv
module xl_load_extract_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 12;
  localparam int IW  = AW - 5;
  localparam int NV  = 16;

  // vector: {wide, signed, size[1:0], addr[11:0]}
  localparam logic [15:0] VEC [NV] = '{
    16'h3000, 16'h0005, 16'h4005, 16'h500E,
    16'h301A, 16'h603D, 16'h2123, 16'h71F9,
    16'h80A0, 16'hF0B0, 16'h80A8, 16'h57FF,
    16'h3FFC, 16'h8FF0, 16'h1444, 16'h42B7
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          req_signed = 1'b0;
  logic          req_wide = 1'b0;
  logic [IW-1:0] even_idx, odd_idx;
  logic [127:0]  even_line, odd_line;
  logic          rsp_valid, rsp_fault;
  logic [127:0]  rsp_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input int odd, input int idx, input int j);
    return 8'((idx * 37 + j * 11 + odd * 101 + 7) & 255);
  endfunction

  function automatic logic [127:0] mk_line(input int odd, input int idx);
    logic [127:0] l;
    for (int j = 0; j < 16; j++) l[8*j +: 8] = pat(odd, idx, j);
    return l;
  endfunction

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return pat(int'(a[4]), int'(a >> 5), int'(a[3:0]));
  endfunction

  assign even_line = mk_line(0, int'(even_idx));
  assign odd_line  = mk_line(1, int'(odd_idx));

  xl_load_extract u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_signed(req_signed), .req_wide(req_wide),
    .even_idx(even_idx), .odd_idx(odd_idx), .even_line(even_line), .odd_line(odd_line),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_data(rsp_data)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [15:0] v);
    logic [AW-1:0] a;
    logic [127:0]  exp_d;
    logic [63:0]   w;
    logic          exp_f;
    int            nb;
    logic [IW-1:0] pidx;
    a = v[11:0];
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = v[13:12]; req_signed = v[14]; req_wide = v[15];
    #1;
    pidx = a[AW-1:5];
    chk("R1/R2 odd_idx", 128'(odd_idx), 128'(pidx));
    if (a[4]) chk("R2 even_idx", 128'(even_idx), 128'(IW'(pidx + 1'b1)));
    else      chk("R1 even_idx", 128'(even_idx), 128'(pidx));
    exp_f = 1'b0;
    if (v[15]) begin
      if (a[3:0] != 4'd0) begin exp_d = '0; exp_f = 1'b1; end  // R8
      else for (int k = 0; k < 16; k++) exp_d[8*k +: 8] = mem_byte(AW'(a + k));  // R7
    end else begin
      for (int k = 0; k < 8; k++) w[8*k +: 8] = mem_byte(AW'(a + k));  // R3
      nb = 1 << v[13:12];                                              // R4
      for (int i = 8*nb; i < 64; i++) w[i] = v[14] ? w[8*nb-1] : 1'b0;  // R4/R5
      exp_d = {64'h0, w};                                              // R6
    end
    @(negedge clk);
    chk("R9 rsp_valid", 128'(rsp_valid), 128'(1));
    chk("R8 rsp_fault", 128'(rsp_fault), 128'(exp_f));
    chk(v[15] ? "R7/R8 wide data" : "R3/R4/R5/R6 narrow data", rsp_data, exp_d);
    req_valid = 1'b0;
  endtask

  initial begin
    logic [127:0] held;
    repeat (3) @(negedge clk);
    req_valid = 1'b1; req_addr = 12'h123; req_size = 2'd3;
    @(negedge clk);
    chk("R10 reset valid", 128'(rsp_valid), 128'(0));
    chk("R10 reset data", rsp_data, 128'h0);
    chk("R10 reset fault", 128'(rsp_fault), 128'(0));
    req_valid = 1'b0;
    rst = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R9: idle cycle with changed inputs leaves data unchanged
    run_vec(16'h7010);
    held = rsp_data;
    req_addr = 12'h555; req_size = 2'd0; req_wide = 1'b1;
    @(negedge clk);
    chk("R9 idle valid", 128'(rsp_valid), 128'(0));
    chk("R9 idle hold", rsp_data, held);

    // R2 wrap of even index at top pair, crossing address zero
    run_vec(16'h7FFA);
    // R7 wide ignores size and signed
    run_vec(16'hB020);

    // R10 reset after activity
    run_vec(16'h8FE8);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 re-reset valid", 128'(rsp_valid), 128'(0));
    chk("R10 re-reset fault", 128'(rsp_fault), 128'(0));
    chk("R10 re-reset data", rsp_data, 128'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule